// File: doc/BRIEF.md
# Tiled Surface Copy Engine

The engine copies one image between a linearly laid out buffer and a tiled buffer, in either direction. The direction is a mode input: decode reads the tiled memory and writes the linear one, and encode does the opposite. After a start pulse the engine visits every texel of the image in row-major order. It works out each texel's linear byte offset itself. An external translator port turns that position into a tiled byte address. The engine then moves the texel from the source memory to the destination memory over two 32-bit word ports.

The texel size is taken from the ratio of pitch to width. Texels that span one or more whole words are copied word by word. Texels of one or two bytes share a word with their neighbours, so the destination word is read, the field is replaced and the word is written back. Texels whose tiled address lands beyond the tile region are left out without any memory access.

Top module: `tile_copy_engine`

## Requirements
- R1: With mode 0 (decode) the tiled port is read and only the linear port is written. With mode 1 (encode) the linear port is read and only the tiled port is written. The source port never receives a write.
- R2: start_i begins a copy. busy_o is high from the cycle after start until the copy ends. done_o is high for exactly one cycle when the copy ends. If the width or the height is zero, done_o is raised without any memory request.
- R3: Texel size bpp is floor(pitch / width). Only the values 1, 2, 4, 8 and 16 are supported. Any other value finishes the walk with no read and no write.
- R4: The linear byte offset of texel (row, col) is row*pitch + col*bpp. The translator receives tile_base + tile_offs + that offset. The tiled data offset is the translator reply minus (tile_base + tile_offs). The texel index on each side is the offset divided by bpp, rounded down.
- R5: A texel of 16, 8 or 4 bytes occupies 4, 2 or 1 consecutive words starting at word index texel*4, texel*2 or texel. These words are moved in ascending order.
- R6: A 2-byte texel sits in word texel>>1 at bit (texel&1)*16. A 1-byte texel sits in word texel>>2 at bit (texel&3)*8.
- R7: Writing a 1- or 2-byte texel reads the destination word, replaces only that field and writes the word back. All other bits keep their previous value.
- R8: A texel whose tiled data offset is greater than or equal to tile_size_i is skipped, with no read and no write.
- R9: At most one memory access is in flight at a time. A request holds its address and type until it is accepted. Read data is taken from the response of the port that was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a copy; sampled while idle |
| mode_i | input | 1 | 0 decode (tiled to linear), 1 encode (linear to tiled) |
| width_i | input | DW | Image width in texels |
| height_i | input | DW | Image height in rows |
| pitch_i | input | AW | Bytes per image row |
| tile_base_i | input | AW | Tile region base byte address |
| tile_offs_i | input | AW | Byte offset of the image inside the region |
| tile_size_i | input | AW | Tile region size in bytes |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle end-of-copy pulse |
| xlat_addr_o | output | AW | Linear-space byte address to translate |
| xlat_addr_i | input | AW | Tiled byte address from the translator (same cycle) |
| tmem_req_valid_o | output | 1 | Tiled memory request valid |
| tmem_req_ready_i | input | 1 | Tiled memory request accepted |
| tmem_req_we_o | output | 1 | Tiled request is a write |
| tmem_req_addr_o | output | AW-2 | Tiled word address |
| tmem_req_wdata_o | output | 32 | Tiled write data |
| tmem_rsp_valid_i | input | 1 | Tiled read data valid |
| tmem_rsp_data_i | input | 32 | Tiled read data |
| lmem_req_valid_o | output | 1 | Linear memory request valid |
| lmem_req_ready_i | input | 1 | Linear memory request accepted |
| lmem_req_we_o | output | 1 | Linear request is a write |
| lmem_req_addr_o | output | AW-2 | Linear word address |
| lmem_req_wdata_o | output | 32 | Linear write data |
| lmem_rsp_valid_i | input | 1 | Linear read data valid |
| lmem_rsp_data_i | input | 32 | Linear read data |

## Verification
The hardest case to reach from the ports is a read-modify-write in which neighbouring sub-word texels land in one destination word in a shuffled order. For that case, each merge must see the word as the previous texel left it. The bench gets there with a translator model that swaps address bits inside the region, so tiled order differs from linear order. It also uses a scoreboard shadow of the destination memory that is updated in walk order, so every expected merged word already includes the earlier merges. Random ready stalls on both ports make requests wait while their address must stay put.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_SRD, ST_SRW, ST_DRD, ST_DRW, ST_WR, ST_NEXT
  } tcp_state_e;

  typedef enum logic {
    MODE_DECODE = 1'b0,
    MODE_ENCODE = 1'b1
  } tcp_mode_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/tcp_bpp_decode.sv
module tcp_bpp_decode #(
  parameter int AW   = 32,
  parameter int DW   = 16,
  parameter int QMAX = 17
) (
  input  logic [AW-1:0] pitch_i,
  input  logic [DW-1:0] width_i,
  output logic          ok_o,
  output logic [2:0]    lg_o
);
  localparam int PW = AW + DW + 6;

  logic [QMAX-1:0] ge;
  logic [4:0]      q;

  // quotient by thermometer: count k with width*k <= pitch
  for (genvar k = 1; k <= QMAX; k++) begin : g_cmp
    assign ge[k-1] = (PW'(width_i) * PW'(k)) <= PW'(pitch_i);
  end

  always_comb begin
    q    = 5'($countones(ge));
    ok_o = 1'b1;
    lg_o = 3'd0;
    case (q)
      5'd1:    lg_o = 3'd0;
      5'd2:    lg_o = 3'd1;
      5'd4:    lg_o = 3'd2;
      5'd8:    lg_o = 3'd3;
      5'd16:   lg_o = 3'd4;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcp_addr_gen.sv
module tcp_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 16,
  localparam int WA = AW - 2
) (
  input  logic [DW-1:0] row_i,
  input  logic [DW-1:0] col_i,
  input  logic [AW-1:0] pitch_i,
  input  logic [2:0]    lg_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] offs_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] xlat_addr_o,
  input  logic [AW-1:0] xlat_addr_i,
  output logic          skip_o,
  output logic [WA-1:0] lin_word_o,
  output logic [1:0]    lin_lane_o,
  output logic [WA-1:0] til_word_o,
  output logic [1:0]    til_lane_o
);
  logic [AW-1:0] lin_off, til_off, region;
  logic [AW-1:0] lin_tex, til_tex;

  function automatic logic [AW-1:0] word_of(input logic [AW-1:0] tex, input logic [2:0] lg);
    if (lg >= 3'd2) return tex << (lg - 3'd2);
    return tex >> (3'd2 - lg);
  endfunction

  always_comb begin
    region      = base_i + offs_i;
    lin_off     = AW'(AW'(row_i) * pitch_i) + (AW'(col_i) << lg_i);
    xlat_addr_o = region + lin_off;
    til_off     = xlat_addr_i - region;
    skip_o      = til_off >= size_i;
    lin_tex     = lin_off >> lg_i;
    til_tex     = til_off >> lg_i;
    lin_word_o  = WA'(word_of(lin_tex, lg_i));
    til_word_o  = WA'(word_of(til_tex, lg_i));
    lin_lane_o  = 2'(lin_tex << lg_i);
    til_lane_o  = 2'(til_tex << lg_i);
  end
endmodule

// File: rtl/tcp_lane_merge.sv
module tcp_lane_merge (
  input  logic [31:0] src_word_i,
  input  logic [1:0]  src_lane_i,
  input  logic [31:0] dst_word_i,
  input  logic [1:0]  dst_lane_i,
  input  logic        half_i,
  output logic [31:0] merged_o
);
  logic [31:0] field, fmask, dmask;

  always_comb begin
    fmask    = half_i ? 32'h0000_ffff : 32'h0000_00ff;
    field    = (src_word_i >> {src_lane_i, 3'b000}) & fmask;
    dmask    = fmask << {dst_lane_i, 3'b000};
    merged_o = (dst_word_i & ~dmask) | ((field << {dst_lane_i, 3'b000}) & dmask);
  end
endmodule

// File: rtl/tile_copy_engine.sv
module tile_copy_engine
  import tcp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  localparam int WA = AW - 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] height_i,
  input  logic [AW-1:0] pitch_i,
  input  logic [AW-1:0] tile_base_i,
  input  logic [AW-1:0] tile_offs_i,
  input  logic [AW-1:0] tile_size_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] xlat_addr_o,
  input  logic [AW-1:0] xlat_addr_i,
  output logic          tmem_req_valid_o,
  input  logic          tmem_req_ready_i,
  output logic          tmem_req_we_o,
  output logic [WA-1:0] tmem_req_addr_o,
  output logic [31:0]   tmem_req_wdata_o,
  input  logic          tmem_rsp_valid_i,
  input  logic [31:0]   tmem_rsp_data_i,
  output logic          lmem_req_valid_o,
  input  logic          lmem_req_ready_i,
  output logic          lmem_req_we_o,
  output logic [WA-1:0] lmem_req_addr_o,
  output logic [31:0]   lmem_req_wdata_o,
  input  logic          lmem_rsp_valid_i,
  input  logic [31:0]   lmem_rsp_data_i
);
  tcp_state_e    state_q;
  tcp_mode_e     mode_q;
  logic [DW-1:0] width_q, height_q, row_q, col_q;
  logic [AW-1:0] pitch_q, base_q, offs_q, size_q;
  logic [1:0]    beat_q, last_beat, src_lane_q, dst_lane_q;
  logic [WA-1:0] src_word_q, dst_word_q;
  logic [31:0]   data_q, wdata_q, merged;
  logic          done_q;

  logic          size_ok, skip, sub;
  logic [2:0]    lg;
  logic [WA-1:0] lin_word, til_word;
  logic [1:0]    lin_lane, til_lane;

  logic          req_til, req_valid, req_we, req_ready, rsp_valid;
  logic [WA-1:0] req_addr;
  logic [31:0]   rsp_data;

  tcp_bpp_decode #(.AW(AW), .DW(DW)) u_bpp (
    .pitch_i(pitch_q), .width_i(width_q), .ok_o(size_ok), .lg_o(lg)
  );

  tcp_addr_gen #(.AW(AW), .DW(DW)) u_addr (
    .row_i(row_q), .col_i(col_q), .pitch_i(pitch_q), .lg_i(lg),
    .base_i(base_q), .offs_i(offs_q), .size_i(size_q),
    .xlat_addr_o(xlat_addr_o), .xlat_addr_i(xlat_addr_i), .skip_o(skip),
    .lin_word_o(lin_word), .lin_lane_o(lin_lane),
    .til_word_o(til_word), .til_lane_o(til_lane)
  );

  tcp_lane_merge u_merge (
    .src_word_i(data_q), .src_lane_i(src_lane_q),
    .dst_word_i(rsp_data), .dst_lane_i(dst_lane_q),
    .half_i(lg[0]), .merged_o(merged)
  );

  always_comb begin
    sub       = lg < 3'd2;
    last_beat = (lg == 3'd4) ? 2'd3 : (lg == 3'd3) ? 2'd1 : 2'd0;
    // source side is tiled in decode, linear in encode
    req_til   = (state_q == ST_SRD || state_q == ST_SRW) ? (mode_q == MODE_DECODE)
                                                         : (mode_q == MODE_ENCODE);
    req_valid = state_q inside {ST_SRD, ST_DRD, ST_WR};
    req_we    = state_q == ST_WR;
    case (state_q)
      ST_SRD:  req_addr = src_word_q + WA'(beat_q);
      ST_WR:   req_addr = dst_word_q + WA'(beat_q);
      default: req_addr = dst_word_q;
    endcase
    req_ready = req_til ? tmem_req_ready_i : lmem_req_ready_i;
    rsp_valid = req_til ? tmem_rsp_valid_i : lmem_rsp_valid_i;
    rsp_data  = req_til ? tmem_rsp_data_i  : lmem_rsp_data_i;
  end

  assign tmem_req_valid_o = req_valid & req_til;
  assign lmem_req_valid_o = req_valid & ~req_til;
  assign tmem_req_we_o    = req_we;
  assign lmem_req_we_o    = req_we;
  assign tmem_req_addr_o  = req_addr;
  assign lmem_req_addr_o  = req_addr;
  assign tmem_req_wdata_o = wdata_q;
  assign lmem_req_wdata_o = wdata_q;
  assign busy_o           = state_q != ST_IDLE;
  assign done_o           = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_DECODE;
      width_q    <= '0;
      height_q   <= '0;
      pitch_q    <= '0;
      base_q     <= '0;
      offs_q     <= '0;
      size_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
      beat_q     <= '0;
      src_word_q <= '0;
      dst_word_q <= '0;
      src_lane_q <= '0;
      dst_lane_q <= '0;
      data_q     <= '0;
      wdata_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q   <= tcp_mode_e'(mode_i);
          width_q  <= width_i;
          height_q <= height_i;
          pitch_q  <= pitch_i;
          base_q   <= tile_base_i;
          offs_q   <= tile_offs_i;
          size_q   <= tile_size_i;
          row_q    <= '0;
          col_q    <= '0;
          if (width_i == '0 || height_i == '0) done_q  <= 1'b1;
          else                                 state_q <= ST_CALC;
        end
        ST_CALC: begin
          if (skip || !size_ok) begin
            state_q <= ST_NEXT;
          end else begin
            src_word_q <= (mode_q == MODE_ENCODE) ? lin_word : til_word;
            dst_word_q <= (mode_q == MODE_ENCODE) ? til_word : lin_word;
            src_lane_q <= (mode_q == MODE_ENCODE) ? lin_lane : til_lane;
            dst_lane_q <= (mode_q == MODE_ENCODE) ? til_lane : lin_lane;
            beat_q     <= '0;
            state_q    <= ST_SRD;
          end
        end
        ST_SRD: if (req_ready) state_q <= ST_SRW;
        ST_SRW: if (rsp_valid) begin
          data_q  <= rsp_data;
          wdata_q <= rsp_data;
          state_q <= sub ? ST_DRD : ST_WR;
        end
        ST_DRD: if (req_ready) state_q <= ST_DRW;
        ST_DRW: if (rsp_valid) begin
          wdata_q <= merged;
          state_q <= ST_WR;
        end
        ST_WR: if (req_ready) begin
          if (beat_q == last_beat) begin
            state_q <= ST_NEXT;
          end else begin
            beat_q  <= beat_q + 2'd1;
            state_q <= ST_SRD;
          end
        end
        ST_NEXT: begin
          if (col_q == width_q - DW'(1)) begin
            col_q <= '0;
            if (row_q == height_q - DW'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              row_q   <= row_q + DW'(1);
              state_q <= ST_CALC;
            end
          end else begin
            col_q   <= col_q + DW'(1);
            state_q <= ST_CALC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcp_chk.sv
module tcp_chk #(
  parameter int WA = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mode_q,
  input logic          tmem_req_valid_o,
  input logic          tmem_req_ready_i,
  input logic          tmem_req_we_o,
  input logic [WA-1:0] tmem_req_addr_o,
  input logic          lmem_req_valid_o,
  input logic          lmem_req_ready_i,
  input logic          lmem_req_we_o,
  input logic [WA-1:0] lmem_req_addr_o
);
  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tmem_req_valid_o && !lmem_req_valid_o);

  // R9
  one_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tmem_req_valid_o && lmem_req_valid_o));

  // R9
  tmem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmem_req_valid_o && !tmem_req_ready_i |=>
      tmem_req_valid_o && $stable(tmem_req_addr_o) && $stable(tmem_req_we_o));

  // R9
  lmem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmem_req_valid_o && !lmem_req_ready_i |=>
      lmem_req_valid_o && $stable(lmem_req_addr_o) && $stable(lmem_req_we_o));

  // R1
  tmem_src_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmem_req_valid_o && tmem_req_we_o |-> mode_q);

  // R1
  lmem_src_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmem_req_valid_o && lmem_req_we_o |-> !mode_q);
endmodule

bind tile_copy_engine tcp_chk #(.WA(AW - 2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .mode_q(mode_q),
  .tmem_req_valid_o(tmem_req_valid_o), .tmem_req_ready_i(tmem_req_ready_i),
  .tmem_req_we_o(tmem_req_we_o), .tmem_req_addr_o(tmem_req_addr_o),
  .lmem_req_valid_o(lmem_req_valid_o), .lmem_req_ready_i(lmem_req_ready_i),
  .lmem_req_we_o(lmem_req_we_o), .lmem_req_addr_o(lmem_req_addr_o)
);

// File: tb/tile_copy_engine_tb.sv
module tile_copy_engine_tb;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int WA = AW - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start, mode, busy, done;
  logic [DW-1:0] width, height;
  logic [AW-1:0] pitch, tbase, toffs, tsize, xl_out, xl_in;
  logic          t_v, t_rdy, t_we, t_rv, l_v, l_rdy, l_we, l_rv;
  logic [WA-1:0] t_addr, l_addr;
  logic [31:0]   t_wd, t_rd, l_wd, l_rd;

  tile_copy_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .width_i(width), .height_i(height), .pitch_i(pitch),
    .tile_base_i(tbase), .tile_offs_i(toffs), .tile_size_i(tsize),
    .busy_o(busy), .done_o(done), .xlat_addr_o(xl_out), .xlat_addr_i(xl_in),
    .tmem_req_valid_o(t_v), .tmem_req_ready_i(t_rdy), .tmem_req_we_o(t_we),
    .tmem_req_addr_o(t_addr), .tmem_req_wdata_o(t_wd),
    .tmem_rsp_valid_i(t_rv), .tmem_rsp_data_i(t_rd),
    .lmem_req_valid_o(l_v), .lmem_req_ready_i(l_rdy), .lmem_req_we_o(l_we),
    .lmem_req_addr_o(l_addr), .lmem_req_wdata_o(l_wd),
    .lmem_rsp_valid_i(l_rv), .lmem_rsp_data_i(l_rd)
  );

  // translator model: swap-style xor of bits 5:4 with bits 9:8
  function automatic logic [31:0] xl(input logic [31:0] a);
    return a ^ (((a >> 8) & 32'h3) << 4);
  endfunction
  assign xl_in = xl(xl_out);

  logic [31:0] tmem [1024];
  logic [31:0] lmem [1024];
  logic [31:0] shadow [1024];
  logic [15:0] lfsr = 16'hACE1;
  assign t_rdy = lfsr[0] | lfsr[3];
  assign l_rdy = lfsr[1] | lfsr[6];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    t_rv <= 1'b0;
    l_rv <= 1'b0;
    if (t_v && t_rdy) begin
      if (t_we) tmem[t_addr[9:0]] <= t_wd;
      else begin t_rv <= 1'b1; t_rd <= tmem[t_addr[9:0]]; end
    end
    if (l_v && l_rdy) begin
      if (l_we) lmem[l_addr[9:0]] <= l_wd;
      else begin l_rv <= 1'b1; l_rd <= lmem[l_addr[9:0]]; end
    end
  end

  typedef struct {
    bit          til;
    logic [31:0] addr;
    logic [31:0] data;
  } exp_t;
  exp_t  expq[$];
  int    checks = 0;
  int    errors = 0;
  int    nreq = 0;
  bit    outst = 1'b0;
  string cur_tag = "";

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and handshake discipline
  always @(negedge clk) begin
    if (rst_n) begin
      if (t_rv || l_rv) outst = 1'b0;
      if ((t_v && t_rdy) || (l_v && l_rdy)) begin
        bit          til;
        bit          we;
        logic [31:0] a, d;
        til = t_v && t_rdy;
        we  = til ? t_we : l_we;
        a   = til ? {2'b00, t_addr} : {2'b00, l_addr};
        d   = til ? t_wd : l_wd;
        nreq++;
        check(!outst, "R9 single access in flight", 32'(outst), 0);
        if (!we) outst = 1'b1;
        else if (expq.size() == 0) begin
          check(1'b0, {cur_tag, " unexpected write"}, a, 32'hffff_ffff);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(til == e.til, "R1 write lands on destination port", 32'(til), 32'(e.til));
          check(a == e.addr && d == e.data, {cur_tag, " write addr"}, a, e.addr);
          if (d != e.data) $display("  data actual=%h expected=%h", d, e.data);
        end
      end
    end
  end

  function automatic logic [31:0] rd_src(input bit m, input logic [31:0] idx);
    return m ? lmem[idx[9:0]] : tmem[idx[9:0]];
  endfunction

  task automatic build_expect(input bit m, input int w, input int h, input logic [31:0] p,
                              input logic [31:0] b, input logic [31:0] o, input logic [31:0] sz);
    logic [31:0] bpp, lo, rg, tof, lt, tt, st, dt, f, dw, d;
    int sh;
    bpp = (w == 0) ? 0 : p / w;
    for (int i = 0; i < 1024; i++) shadow[i] = m ? tmem[i] : lmem[i];
    if (!(bpp inside {1, 2, 4, 8, 16})) return;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        lo  = r * p + c * bpp;
        rg  = b + o;
        tof = xl(rg + lo) - rg;
        if (tof >= sz) continue;
        lt = lo / bpp;
        tt = tof / bpp;
        st = m ? lt : tt;
        dt = m ? tt : lt;
        if (bpp >= 4) begin
          for (int k = 0; k < int'(bpp / 4); k++) begin
            d = rd_src(m, st * (bpp / 4) + k);
            expq.push_back('{m, dt * (bpp / 4) + k, d});
            shadow[10'(dt * (bpp / 4) + k)] = d;
          end
        end else if (bpp == 2) begin
          f  = (rd_src(m, st >> 1) >> ((st & 1) * 16)) & 32'hffff;
          dw = dt >> 1;
          sh = int'((dt & 1) * 16);
          d  = (shadow[dw[9:0]] & ~(32'hffff << sh)) | (f << sh);
          expq.push_back('{m, dw, d});
          shadow[dw[9:0]] = d;
        end else begin
          f  = (rd_src(m, st >> 2) >> ((st & 3) * 8)) & 32'hff;
          dw = dt >> 2;
          sh = int'((dt & 3) * 8);
          d  = (shadow[dw[9:0]] & ~(32'hff << sh)) | (f << sh);
          expq.push_back('{m, dw, d});
          shadow[dw[9:0]] = d;
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input bit m, input int w, input int h,
                          input logic [31:0] p, input logic [31:0] o, input logic [31:0] sz,
                          input bit quiet);
    int cnt;
    int n0;
    for (int i = 0; i < 1024; i++) begin
      tmem[i] = (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0000;
      lmem[i] = ~(32'h0100_0193 * (i + 7));
    end
    cur_tag = tag;
    expq.delete();
    build_expect(m, w, h, p, 32'h1000, o, sz);
    n0 = nreq;
    @(negedge clk);
    mode = m; width = DW'(w); height = DW'(h); pitch = p;
    tbase = 32'h1000; toffs = o; tsize = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (w != 0 && h != 0) check(busy == 1'b1, {tag, " R2 busy after start"}, 32'(busy), 1);
    cnt = 0;
    while (!done && cnt < 20000) begin @(negedge clk); cnt++; end
    check(done == 1'b1, {tag, " R2 done raised"}, 32'(done), 1);
    check(busy == 1'b0, {tag, " R2 idle at done"}, 32'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R2 done one cycle"}, 32'(done), 0);
    check(expq.size() == 0, {tag, " all expected writes seen"}, 32'(expq.size()), 0);
    if (quiet) check(nreq == n0, {tag, " no memory access"}, 32'(nreq - n0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    start = 1'b0; mode = 1'b0; width = '0; height = '0; pitch = '0;
    tbase = '0; toffs = '0; tsize = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !t_v && !l_v, "R2 reset state",
          {28'h0, busy, done, t_v, l_v}, 0);
    run_case("R5 4-byte decode",             1'b0, 8,  4, 32, 32'h140, 32'd1024, 1'b0);
    run_case("R6 R7 1-byte decode rmw",      1'b0, 16, 3, 16, 32'h140, 32'd1024, 1'b0);
    run_case("R6 R7 2-byte encode rmw",      1'b1, 8,  4, 16, 32'h1c0, 32'd1024, 1'b0);
    run_case("R5 8-byte decode",             1'b0, 4,  2, 32, 32'h140, 32'd1024, 1'b0);
    run_case("R5 R1 16-byte encode",         1'b1, 2,  3, 32, 32'h100, 32'd1024, 1'b0);
    run_case("R8 out-of-region skip",        1'b1, 8,  4, 32, 32'h140, 32'd40,   1'b0);
    run_case("R4 pitch not multiple of bpp", 1'b0, 8,  3, 34, 32'h140, 32'd1024, 1'b0);
    run_case("R3 unsupported texel size",    1'b0, 8,  2, 24, 32'h140, 32'd1024, 1'b1);
    run_case("R2 zero height",               1'b1, 8,  0, 32, 32'h140, 32'd1024, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule